// File: doc/BRIEF.md
# Mode-0 SPI Slave with Attention Request

This block is a byte-wide serial peripheral interface slave for clock mode 0 (clock idles low, data sampled on the rising edge). An external master owns the serial clock and the active-low select. The block samples the three input pins with the system clock, finds clock and select edges in that domain, and moves whole bytes. On the system side it delivers each received byte as a one-cycle pulse. It takes transmit bytes through a valid/ready handshake that holds one byte.

The master cannot know when the slave has something to say, so the block drives an active-low attention output. It pulls that output low as soon as a transmit byte is waiting, and releases it once that byte has been fully clocked out. If a session is already running when a byte is offered, the byte goes out at the next byte boundary, in parallel with whatever the master is sending. A slot with nothing to send carries an all-ones filler byte. The data output enable is high only while the slave is selected, so the line can be shared. The system clock must run at least four times faster than the serial clock.

Top module: `spi_attn_slave`

## Requirements
- R1: After reset, miso_oe_o is 0, attn_n_o is 1, tx_ready_o is 1 and rx_valid_o is 0.
- R2: MOSI is sampled on each rising SCLK edge while SSEL is low, most significant bit first. After the eighth rising edge, rx_valid_o pulses high for exactly one cycle with the assembled byte on rx_data_o.
- R3: MISO presents bit 7 of the current byte before the first rising SCLK edge of that byte, and moves to the next lower bit only after a falling SCLK edge. Between such events MISO holds its value.
- R4: miso_oe_o is 1 while the synchronised select is low, and 0 while it is high.
- R5: attn_n_o goes low in the cycle after a transmit byte is accepted. It stays low until the last bit of the last pending byte has been sampled by the master.
- R6: A byte slot for which no transmit byte is held carries the value 0xFF on MISO.
- R7: A transmit byte accepted while a session is running, in the middle of a byte, goes out in the next byte slot.
- R8: tx_ready_o is 1 exactly when the single holding slot is empty. The held byte is consumed when select falls or at a byte boundary, so back-to-back bytes stream without gaps.
- R9: Raising SSEL part-way through a byte discards the partial byte, with no rx_valid_o pulse. It also resets the bit count, so the next session starts with a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from master |
| ssel_n_i | input | 1 | Active-low slave select from master |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Output enable for miso_o (tri-state control) |
| attn_n_o | output | 1 | Active-low request for the master to clock data out |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | tx_data_i is offered |
| tx_ready_o | output | 1 | Holding slot is free |

## Verification
A bit counter that is out of step shows up at once on both sides. Received bytes come out rotated or land on the wrong edge, and the outgoing byte is reloaded in mid-byte, so MISO goes wrong within the same byte. A stale holding or in-flight flag shows up as attention stuck low after a session drains, or as a byte sent twice or dropped. The bench catches these by comparing every byte in both directions, and by checking attention and ready once a session has drained. A counter left uncleared after an aborted byte corrupts the very next received byte.

// File: rtl/spi_attn_pkg.sv
package spi_attn_pkg;
  // index of each pin inside the synchroniser bundle
  typedef enum int unsigned {
    PIN_SCLK = 0,
    PIN_SSEL = 1,
    PIN_MOSI = 2
  } pin_idx_e;

  localparam int unsigned NUM_PINS = 3;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  // reset levels of the synchronised pins: clock low, select high, data low
  localparam logic [NUM_PINS-1:0] PIN_RST = 3'b010;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              ssel_n_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              miso,
  output logic              active,
  output logic              byte_done,
  output logic              load_evt
);
  localparam int unsigned CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] r,
                                                 input logic b);
    return {r[DATA_W-2:0], b};
  endfunction

  logic sclk_d, ssel_n_d;
  logic sclk_rise, sclk_fall, sel_fall;
  logic [CW-1:0] cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      ssel_n_d <= 1'b1;
    end else begin
      sclk_d   <= sclk_s;
      ssel_n_d <= ssel_n_s;
    end
  end

  assign active    = ~ssel_n_s;
  assign sclk_rise = active & sclk_s & ~sclk_d;
  assign sclk_fall = active & ~sclk_s & sclk_d;
  assign sel_fall  = ssel_n_d & ~ssel_n_s;
  assign byte_done = sclk_rise & (cnt == LAST);
  assign load_evt  = sel_fall | (sclk_fall & (cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!active) cnt <= '0;
    else if (sclk_rise) cnt <= next_cnt(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= byte_done;
      if (sclk_rise) rx_sh <= shift_in(rx_sh, mosi_s);
      if (byte_done) rx_data <= shift_in(rx_sh, mosi_s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_sh <= '1;
    else if (load_evt) tx_sh <= load_data;
    else if (sclk_fall) tx_sh <= shift_in(tx_sh, 1'b1);
  end

  assign miso = tx_sh[DATA_W-1];

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R3
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !sclk_fall) |=> $stable(miso));
endmodule

// File: rtl/spi_tx_feed.sv
module spi_tx_feed #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load_evt,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] load_data,
  output logic              attn_n
);
  logic hold_v, in_flight;
  logic [DATA_W-1:0] hold_d;
  logic accept, pop;

  assign tx_ready  = ~hold_v;
  assign accept    = tx_valid & ~hold_v;
  assign pop       = load_evt & hold_v;
  assign load_data = hold_v ? hold_d : FILL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (pop) begin
      hold_v <= 1'b0;
    end else if (accept) begin
      hold_v <= 1'b1;
      hold_d <= tx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_flight <= 1'b0;
    else if (load_evt) in_flight <= hold_v;
    else if (byte_done || !active) in_flight <= 1'b0;
  end

  assign attn_n = ~(hold_v | in_flight);

  // R5
  attn_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !attn_n);
  // R8
  ready_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> tx_ready);
endmodule

// File: rtl/spi_attn_slave.sv
module spi_attn_slave
  import spi_attn_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              ssel_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              attn_n_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  logic [NUM_PINS-1:0] pins_raw, pins_s;
  logic active, byte_done, load_evt;
  logic [DATA_W-1:0] load_data;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCLK] = sclk_i;
    pins_raw[PIN_SSEL] = ssel_n_i;
    pins_raw[PIN_MOSI] = mosi_i;
  end

  spi_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_DEPTH), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[PIN_SCLK]), .ssel_n_s(pins_s[PIN_SSEL]), .mosi_s(pins_s[PIN_MOSI]),
    .load_data(load_data), .rx_data(rx_data_o), .rx_valid(rx_valid_o),
    .miso(miso_o), .active(active), .byte_done(byte_done), .load_evt(load_evt));

  spi_tx_feed #(.DATA_W(DATA_W), .FILL(FILL)) u_feed (
    .clk(clk), .rst_n(rst_n), .active(active), .load_evt(load_evt),
    .byte_done(byte_done), .tx_data(tx_data_i), .tx_valid(tx_valid_i),
    .tx_ready(tx_ready_o), .load_data(load_data), .attn_n(attn_n_o));

  assign miso_oe_o = active;

  // R4
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> miso_oe_o);
endmodule

// File: tb/test_spi_attn_slave.sv
module test_spi_attn_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, ssel_n = 1, mosi = 0;
  logic miso, miso_oe, attn_n, rx_valid, tx_valid = 0, tx_ready;
  logic [7:0] rx_data, tx_data = 0;
  int chk_cnt = 0, fail_cnt = 0;
  logic [7:0] exp_rx[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_attn_slave i_spi_attn_slave (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ssel_n_i(ssel_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .attn_n_o(attn_n),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
    $finish;
  endtask

  // monitor: pops the scoreboard on every received byte (R2, R9)
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) check(0, "R9 unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R2 rx byte", rx_data, e);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // master shifts one byte and captures the slave's byte; scoreboard gets mosi byte
  task automatic xfer(input logic [7:0] out_b, output logic [7:0] in_b);
    exp_rx.push_back(out_b);
    for (int i = 7; i >= 0; i--) begin
      mosi = out_b[i];
      wait_cyc(HALF);
      in_b[i] = miso;
      sclk = 1;
      wait_cyc(HALF);
      sclk = 0;
    end
  endtask

  task automatic select();
    ssel_n = 0;
    wait_cyc(HALF);
  endtask

  task automatic deselect();
    wait_cyc(HALF);
    ssel_n = 1;
    wait_cyc(HALF);
  endtask

  task automatic push_tx(input logic [7:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data = b;
    tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
  endtask

  initial begin
    wait_cyc(200000);
    check(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    logic [7:0] m1, m2, m3;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    // R1 reset state
    check(miso_oe == 0 && attn_n == 1 && tx_ready == 1 && rx_valid == 0, "R1 reset",
          {miso_oe, attn_n, tx_ready, rx_valid}, 4'b0110);

    // plain receive, no tx data: filler (R2, R6), oe while selected (R4)
    select();
    check(miso_oe == 1, "R4 oe selected", miso_oe, 1);
    xfer(8'hA5, m1);
    check(m1 == 8'hFF, "R6 filler", m1, 8'hFF);
    check(attn_n == 1, "R5 no attention when idle", attn_n, 1);
    deselect();
    check(miso_oe == 0, "R4 oe deselected", miso_oe, 0);

    // attention and data byte, MSB first (R3, R5, R8)
    push_tx(8'h3C);
    check(attn_n == 0, "R5 attention on pending", attn_n, 0);
    check(tx_ready == 0, "R8 slot full", tx_ready, 0);
    select();
    xfer(8'h0F, m1);
    check(m1 == 8'h3C, "R3 tx byte msb first", m1, 8'h3C);
    wait_cyc(4);
    check(attn_n == 1, "R5 attention released", attn_n, 1);
    check(tx_ready == 1, "R8 slot free", tx_ready, 1);
    deselect();

    // data offered mid-byte goes out in next slot (R7)
    select();
    fork
      xfer(8'h11, m1);
      begin wait_cyc(20); push_tx(8'h5A); end
    join
    check(m1 == 8'hFF, "R7 current slot keeps filler", m1, 8'hFF);
    xfer(8'h22, m2);
    check(m2 == 8'h5A, "R7 next slot carries data", m2, 8'h5A);
    deselect();

    // back-to-back stream then filler (R8, R6)
    push_tx(8'hC3);
    select();
    fork
      begin xfer(8'h81, m1); xfer(8'h42, m2); xfer(8'h24, m3); end
      push_tx(8'h7E);
    join
    check(m1 == 8'hC3, "R8 first streamed byte", m1, 8'hC3);
    check(m2 == 8'h7E, "R8 second streamed byte", m2, 8'h7E);
    check(m3 == 8'hFF, "R6 filler after drain", m3, 8'hFF);
    check(attn_n == 1, "R5 released after stream", attn_n, 1);
    deselect();

    // aborted partial byte is dropped, next session aligned (R9)
    select();
    for (int i = 0; i < 4; i++) begin
      mosi = 1; wait_cyc(HALF); sclk = 1; wait_cyc(HALF); sclk = 0;
    end
    deselect();
    select();
    xfer(8'h96, m1);
    deselect();
    wait_cyc(10);
    check(exp_rx.size() == 0, "R9 all rx bytes seen", exp_rx.size(), 0);
    report();
  end
endmodule